// File: doc/BRIEF.md
# Flag-setting integer ALU

This block is the execute-stage arithmetic and logic unit of a compact 16-bit-encoded RISC core. Each cycle in which `in_valid` is high, it takes two operands, an operation code and the present condition flags (N, Z, C, V). It registers the result, the next flag values and a write enable. These appear on its outputs one clock later, with `out_valid` high.

Each class of operation touches its own subset of the flags. The arithmetic class sets all four. The bitwise, move and multiply class sets only N and Z and carries C and V through. The shift class sets N and Z, and sets C to the last bit shifted out. A shift of length zero leaves C alone.

The two compare operations set the flags and drop the write enable, so that the register file keeps its old value. The difference or sum still appears on `result_o`. Decode, the register file and memory live outside this block.

Top module: `flag_alu`

## Requirements
- R1: A result, its flags and its write enable appear on the outputs on the rising edge after the one that sampled `in_valid` high. `out_valid` is high in exactly those cycles. While reset is asserted (`rst_n` low), `out_valid`, `result_o`, `flags_o` and `wr_o` are all zero. Flags are packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V, on both `flags_i` and `flags_o`.
- R2: Code 0 (add) and code 3 (compare-negative) compute a+b. C is the carry out of bit 31. V is set when both operands have the same sign and the sum has the other sign.
- R3: Code 1 (subtract) and code 2 (compare) compute a-b. C is 1 exactly when a is unsigned greater than or equal to b. V is set when the operands differ in sign and the result's sign differs from a.
- R4: Code 4 (negate) computes 0-a. C is 1 only for a = 0. V is 1 only for a = 0x80000000.
- R5: Codes 2 and 3 give `wr_o` = 0 and every other code from 0 to 17 gives `wr_o` = 1. Codes 18 to 31 give `wr_o` = 0, return a as the result and pass all four flags through unchanged.
- R6: The bitwise codes are 5 (a AND b), 6 (a OR b), 7 (a XOR b), 8 (a AND NOT b), 9 (NOT b) and 10 (move b).
- R7: Code 11 returns the low 32 bits of a*b. This value does not depend on whether the operands are read as signed or unsigned.
- R8: Codes 5 to 11 pass C and V through from `flags_i` unchanged.
- R9: Code 12 shifts a left by b[4:0] (0 to 31). Code 15 shifts a left by b[7:0]. Zeros enter at bit 0, and C is the last bit shifted out. A shift of 32 gives 0 with C = a[0]. A shift above 32 gives 0 with C = 0.
- R10: Codes 13 (logical right) and 14 (arithmetic right) take their length from b[4:0], where 0 stands for a shift of 32. A shift of 32 gives all zeros (logical) or all copies of a[31] (arithmetic), with C = a[31].
- R11: Codes 16 (logical right) and 17 (arithmetic right) take their length from b[7:0], and b[31:8] has no effect. Above 32, the logical shift gives 0 with C = 0, and the arithmetic shift gives sign fill with C = a[31]. For codes 12 to 17, an effective length of 0 returns a and keeps the incoming C.
- R12: For every code from 0 to 17, N equals result bit 31 and Z is 1 exactly when the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand, the value that is shifted |
| b_i | input | 32 | Second operand, or shift length |
| flags_i | input | 4 | Current N, Z, C, V |
| out_valid | output | 1 | Registered result is valid |
| result_o | output | 32 | Registered result |
| flags_o | output | 4 | Next N, Z, C, V |
| wr_o | output | 1 | Result should be written back |

## Verification
Every output of this block is due exactly one rising edge after the edge that captures `in_valid`. There is no variable latency for any code, including the register-specified shifts of up to 255 places.

The bench drives a new operation on each falling edge and pushes the expected value into a queue at the same moment. Its monitor checks outputs only on falling edges where `out_valid` is high, popping items in order. A result that arrives a cycle early or late therefore pairs with the wrong item or leaves the queue non-empty, and both cases are reported. Back-to-back streams confirm that one operation never spills into the next.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_CMP   = 5'd2,
        OP_CMN   = 5'd3,
        OP_RSB   = 5'd4,
        OP_AND   = 5'd5,
        OP_ORR   = 5'd6,
        OP_EOR   = 5'd7,
        OP_BIC   = 5'd8,
        OP_MVN   = 5'd9,
        OP_MOV   = 5'd10,
        OP_MUL   = 5'd11,
        OP_LSL_I = 5'd12,
        OP_LSR_I = 5'd13,
        OP_ASR_I = 5'd14,
        OP_LSL_R = 5'd15,
        OP_LSR_R = 5'd16,
        OP_ASR_R = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         ci;

    always_comb begin
        x  = a;
        y  = b;
        ci = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: begin
                y  = ~b;
                ci = 1'b1;
            end
            OP_RSB: begin
                x  = '0;
                y  = ~a;
                ci = 1'b1;
            end
            default: ;
        endcase
        {cout, sum} = {1'b0, x} + {1'b0, y} + (W+1)'(ci);
        ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);

    logic [W-1:0] prod;

    assign prod = a * b;

    always_comb begin
        res = a;
        unique case (op)
            OP_AND:  res = a & b;
            OP_ORR:  res = a | b;
            OP_EOR:  res = a ^ b;
            OP_BIC:  res = a & ~b;
            OP_MVN:  res = ~b;
            OP_MOV:  res = b;
            OP_MUL:  res = prod;
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import flag_alu_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);

    localparam int              FW   = $clog2(W);
    localparam logic [SH_W-1:0] FULL = SH_W'(W);

    typedef enum logic [1:0] {K_NONE, K_LEFT, K_RLOG, K_RARI} kind_e;

    kind_e             kind;
    logic [SH_W-1:0]   amt;
    logic [SH_W-1:0]   amt_sat;
    logic [FW-1:0]     fld;
    logic [W:0]        lwide;
    logic [W:0]        rwide;
    logic signed [W:0] swide;

    assign fld = b[FW-1:0];

    // length selection: immediate field or low byte of the register operand
    always_comb begin
        kind = K_NONE;
        amt  = '0;
        unique case (op)
            OP_LSL_I: begin kind = K_LEFT; amt = SH_W'(fld); end
            OP_LSR_I: begin kind = K_RLOG; amt = (fld == '0) ? FULL : SH_W'(fld); end
            OP_ASR_I: begin kind = K_RARI; amt = (fld == '0) ? FULL : SH_W'(fld); end
            OP_LSL_R: begin kind = K_LEFT; amt = b[SH_W-1:0]; end
            OP_LSR_R: begin kind = K_RLOG; amt = b[SH_W-1:0]; end
            OP_ASR_R: begin kind = K_RARI; amt = b[SH_W-1:0]; end
            default: ;
        endcase
    end

    // one extra bit beside the operand catches the last bit shifted out
    always_comb begin
        res     = a;
        cout    = cin;
        amt_sat = (amt > FULL) ? FULL : amt;
        lwide   = {1'b0, a} << amt_sat;
        rwide   = {a, 1'b0} >> amt_sat;
        swide   = $signed({a, 1'b0}) >>> amt_sat;
        if (kind != K_NONE && amt != '0) begin
            unique case (kind)
                K_LEFT: begin
                    res  = lwide[W-1:0];
                    cout = (amt > FULL) ? 1'b0 : lwide[W];
                end
                K_RLOG: begin
                    res  = rwide[W:1];
                    cout = (amt > FULL) ? 1'b0 : rwide[0];
                end
                default: begin
                    res  = swide[W:1];
                    cout = swide[0];
                end
            endcase
        end
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [3:0]        flags_i,
    output logic              out_valid,
    output logic [W-1:0]      result_o,
    output logic [3:0]        flags_o,
    output logic              wr_o
);

    alu_op_e     op;
    alu_flags_t  fin;
    alu_flags_t  nf_d;
    alu_flags_t  flags_q;
    logic [W-1:0] res_d;
    logic [W-1:0] res_q;
    logic         wr_d;
    logic         wr_q;
    logic         vld_q;
    logic         upd_nz;

    logic [W-1:0] as_sum;
    logic         as_c;
    logic         as_v;
    logic [W-1:0] lg_res;
    logic [W-1:0] sh_res;
    logic         sh_c;

    assign op  = alu_op_e'(op_i);
    assign fin = alu_flags_t'(flags_i);

    alu_addsub #(.W(W)) i_addsub (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .sum  (as_sum),
        .cout (as_c),
        .ovf  (as_v)
    );

    alu_logic #(.W(W)) i_logic (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .res (lg_res)
    );

    alu_shift #(.W(W), .SH_W(SH_W)) i_shift (
        .op   (op),
        .a    (a_i),
        .b    (b_i),
        .cin  (fin.c),
        .res  (sh_res),
        .cout (sh_c)
    );

    // next-value selection per operation class
    always_comb begin
        res_d  = a_i;
        nf_d   = fin;
        wr_d   = 1'b0;
        upd_nz = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_RSB, OP_CMP, OP_CMN: begin
                res_d  = as_sum;
                nf_d.c = as_c;
                nf_d.v = as_v;
                wr_d   = (op != OP_CMP) && (op != OP_CMN);
                upd_nz = 1'b1;
            end
            OP_AND, OP_ORR, OP_EOR, OP_BIC, OP_MVN, OP_MOV, OP_MUL: begin
                res_d  = lg_res;
                wr_d   = 1'b1;
                upd_nz = 1'b1;
            end
            OP_LSL_I, OP_LSR_I, OP_ASR_I, OP_LSL_R, OP_LSR_R, OP_ASR_R: begin
                res_d  = sh_res;
                nf_d.c = sh_c;
                wr_d   = 1'b1;
                upd_nz = 1'b1;
            end
            default: ;
        endcase
        if (upd_nz) begin
            nf_d.n = res_d[W-1];
            nf_d.z = (res_d == '0);
        end
    end

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            res_q   <= '0;
            flags_q <= '0;
            wr_q    <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q   <= res_d;
                flags_q <= nf_d;
                wr_q    <= wr_d;
            end
        end
    end

    assign out_valid = vld_q;
    assign result_o  = res_q;
    assign flags_o   = flags_q;
    assign wr_o      = wr_q;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    a_i,
    input logic [W-1:0]    b_i,
    input logic [3:0]      flags_i,
    input logic            out_valid,
    input logic [W-1:0]    result_o,
    input logic [3:0]      flags_o,
    input logic            wr_o
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
    AST_ADD_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_i == OP_ADD) |=> flags_o[1] == (({1'b0, $past(a_i)} + {1'b0, $past(b_i)}) >> W)); // R2
    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_i == OP_SUB) |=> flags_o[1] == ($past(a_i) >= $past(b_i))); // R3
    AST_COMPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && (op_i == OP_CMP || op_i == OP_CMN)) |=> !wr_o); // R5
    AST_BITWISE_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_i >= OP_AND && op_i <= OP_MUL) |=> flags_o[1:0] == $past(flags_i[1:0])); // R8
    AST_ZERO_SHIFT_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_i >= OP_LSL_R && op_i <= OP_ASR_R && b_i[7:0] == 8'd0) |=> flags_o[1] == $past(flags_i[1])); // R11
    AST_N_FOLLOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && wr_o) |-> flags_o[3] == result_o[W-1]); // R12
    AST_Z_FOLLOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && wr_o) |-> flags_o[2] == (result_o == '0)); // R12

endmodule

bind flag_alu flag_alu_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .flags_i   (flags_i),
    .out_valid (out_valid),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .wr_o      (wr_o)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] C_ADD = 5'd0,  C_SUB = 5'd1,  C_CMP = 5'd2,  C_CMN = 5'd3;
    localparam logic [4:0] C_RSB = 5'd4,  C_AND = 5'd5,  C_ORR = 5'd6,  C_EOR = 5'd7;
    localparam logic [4:0] C_BIC = 5'd8,  C_MVN = 5'd9,  C_MOV = 5'd10, C_MUL = 5'd11;
    localparam logic [4:0] C_LSLI = 5'd12, C_LSRI = 5'd13, C_ASRI = 5'd14;
    localparam logic [4:0] C_LSLR = 5'd15, C_LSRR = 5'd16, C_ASRR = 5'd17;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  fl;
        logic        wr;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [3:0]  flags_i = '0;
    logic        out_valid;
    logic [31:0] result_o;
    logic [3:0]  flags_o;
    logic        wr_o;

    int   tests = 0;
    int   fails = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu i_flag_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_i      (op_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .flags_i   (flags_i),
        .out_valid (out_valid),
        .result_o  (result_o),
        .flags_o   (flags_o),
        .wr_o      (wr_o)
    );

    // bit-serial reference for shifts, written from the requirements
    function automatic exp_t model(logic [4:0] op, logic [31:0] a, logic [31:0] b,
                                   logic [3:0] f, string req);
        exp_t        e;
        logic [32:0] t;
        logic [31:0] x;
        logic        c;
        int          amt;
        e.req = req;
        e.res = a;
        e.fl  = f;
        e.wr  = 1'b0;
        c     = f[1];
        if (op == C_ADD || op == C_CMN) begin
            t = {1'b0, a} + {1'b0, b};
            e.res = t[31:0];
            e.fl[1] = t[32];
            e.fl[0] = (a[31] == b[31]) && (e.res[31] != a[31]);
            e.wr = (op == C_ADD);
        end else if (op == C_SUB || op == C_CMP) begin
            e.res = a - b;
            e.fl[1] = (a >= b);
            e.fl[0] = (a[31] != b[31]) && (e.res[31] != a[31]);
            e.wr = (op == C_SUB);
        end else if (op == C_RSB) begin
            e.res = 32'd0 - a;
            e.fl[1] = (a == 32'd0);
            e.fl[0] = (a == 32'h8000_0000);
            e.wr = 1'b1;
        end else if (op >= C_AND && op <= C_MUL) begin
            case (op)
                C_AND:   e.res = a & b;
                C_ORR:   e.res = a | b;
                C_EOR:   e.res = a ^ b;
                C_BIC:   e.res = a & ~b;
                C_MVN:   e.res = ~b;
                C_MOV:   e.res = b;
                default: e.res = a * b;
            endcase
            e.wr = 1'b1;
        end else if (op >= C_LSLI && op <= C_ASRR) begin
            if (op >= C_LSLR) amt = int'(b[7:0]);
            else if (op == C_LSLI) amt = int'(b[4:0]);
            else amt = (b[4:0] == 5'd0) ? 32 : int'(b[4:0]);
            x = a;
            for (int i = 0; i < amt; i++) begin
                if (op == C_LSLI || op == C_LSLR) begin
                    c = x[31]; x = x << 1;
                end else if (op == C_LSRI || op == C_LSRR) begin
                    c = x[0]; x = x >> 1;
                end else begin
                    c = x[0]; x = {x[31], x[31:1]};
                end
            end
            e.res = x;
            e.fl[1] = c;
            e.wr = 1'b1;
        end
        if (op <= C_ASRR) begin
            e.fl[3] = e.res[31];
            e.fl[2] = (e.res == 32'd0);
        end
        return e;
    endfunction

    task automatic drive(logic [4:0] op, logic [31:0] a, logic [31:0] b,
                         logic [3:0] f, string req);
        @(negedge clk);
        op_i     = op;
        a_i      = a;
        b_i      = b;
        flags_i  = f;
        in_valid = 1'b1;
        sb.push_back(model(op, a, b, f, req));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: outputs settle after the capturing rising edge, compared at the falling edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            tests++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (result_o !== e.res || flags_o !== e.fl || wr_o !== e.wr) begin
                    fails++;
                    $display("FAIL %s: actual res=%h fl=%b wr=%b expected res=%h fl=%b wr=%b",
                             e.req, result_o, flags_o, wr_o, e.res, e.fl, e.wr);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL R1 watchdog: actual pending=%0d expected finished", sb.size());
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || result_o !== 32'd0 || flags_o !== 4'd0 || wr_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state: actual v=%b r=%h f=%b w=%b expected all zero",
                     out_valid, result_o, flags_o, wr_o);
        end
        rst_n = 1'b1;
        idle(2);

        // R2 add and compare-negative
        drive(C_ADD, 32'd1, 32'd2, 4'b0000, "R2 add small");
        drive(C_ADD, 32'hFFFF_FFFF, 32'd1, 4'b0000, "R2 add carry to zero");
        drive(C_ADD, 32'h7FFF_FFFF, 32'd1, 4'b0011, "R2 add signed overflow");
        drive(C_CMN, 32'd5, 32'hFFFF_FFFB, 4'b0000, "R2 R5 compare-negative equal");
        idle(1);
        // R3 subtract and compare
        drive(C_SUB, 32'd5, 32'd3, 4'b0000, "R3 sub no borrow");
        drive(C_SUB, 32'd3, 32'd5, 4'b0010, "R3 sub borrow");
        drive(C_SUB, 32'h8000_0000, 32'd1, 4'b0000, "R3 sub overflow");
        drive(C_CMP, 32'd77, 32'd77, 4'b0000, "R3 R5 compare equal");
        drive(C_CMP, 32'd1, 32'hFFFF_FFFF, 4'b1111, "R3 R5 compare below");
        // R4 negate
        drive(C_RSB, 32'd0, 32'h1234, 4'b0000, "R4 negate zero");
        drive(C_RSB, 32'd1, 32'd0, 4'b0010, "R4 negate one");
        drive(C_RSB, 32'h8000_0000, 32'd0, 4'b0000, "R4 negate most negative");
        idle(2);
        // R6 R8 bitwise with C and V set on entry
        drive(C_AND, 32'hF0F0_1234, 32'h0FF0_FF00, 4'b0011, "R6 R8 and");
        drive(C_ORR, 32'h8000_0000, 32'h0000_0005, 4'b0011, "R6 R8 or");
        drive(C_EOR, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b0001, "R6 R8 xor to zero");
        drive(C_BIC, 32'hFFFF_FFFF, 32'h0000_0025, 4'b0010, "R6 R8 bit clear");
        drive(C_MVN, 32'd9, 32'h0000_00FF, 4'b0011, "R6 R8 not");
        drive(C_MOV, 32'd9, 32'd0, 4'b1011, "R6 R8 move zero");
        // R7 multiply
        drive(C_MUL, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0011, "R7 R8 mul minus one squared");
        drive(C_MUL, 32'h0001_0000, 32'h0001_0000, 4'b0000, "R7 mul wraps to zero");
        drive(C_MUL, 32'hFFFF_FFFE, 32'd3, 4'b0000, "R7 mul signed negative");
        idle(1);
        // R9 left shifts
        drive(C_LSLI, 32'h8000_0001, 32'd1, 4'b0000, "R9 lsl imm 1");
        drive(C_LSLI, 32'h0000_0003, 32'd31, 4'b0000, "R9 lsl imm 31");
        drive(C_LSLI, 32'h8000_0000, 32'd0, 4'b0010, "R9 R11 lsl imm 0 keeps C");
        drive(C_LSLR, 32'h0000_0001, 32'd32, 4'b0000, "R9 lsl reg 32");
        drive(C_LSLR, 32'hFFFF_FFFF, 32'd33, 4'b0010, "R9 lsl reg 33");
        // R10 immediate right shifts
        drive(C_LSRI, 32'h8000_0000, 32'd0, 4'b0000, "R10 lsr imm field 0 is 32");
        drive(C_LSRI, 32'h0000_0003, 32'd1, 4'b0000, "R10 lsr imm 1");
        drive(C_ASRI, 32'h8000_0000, 32'd0, 4'b0000, "R10 asr imm field 0 is 32");
        drive(C_ASRI, 32'h8000_00F0, 32'd4, 4'b0010, "R10 asr imm 4");
        drive(C_ASRI, 32'h4000_0000, 32'd0, 4'b0010, "R10 asr imm 32 positive");
        // R11 register right shifts
        drive(C_LSRR, 32'h8000_0000, 32'h0000_0021, 4'b0010, "R11 lsr reg 33");
        drive(C_LSRR, 32'h0000_00F0, 32'hFFFF_FF04, 4'b0000, "R11 lsr reg upper bits ignored");
        drive(C_LSRR, 32'h0000_0001, 32'h0000_0100, 4'b0010, "R11 lsr reg length 0 keeps C");
        drive(C_ASRR, 32'h8000_0000, 32'd200, 4'b0000, "R11 asr reg 200");
        drive(C_ASRR, 32'h1234_5678, 32'd255, 4'b0010, "R11 asr reg 255 positive");
        drive(C_LSLR, 32'h0000_0001, 32'h0000_1204, 4'b0000, "R11 lsl reg upper bits ignored");
        // R5 unused code
        drive(5'd20, 32'hDEAD_BEEF, 32'd1, 4'b1010, "R5 unused code");
        drive(5'd31, 32'd0, 32'd0, 4'b0101, "R5 unused code 31");
        idle(4);

        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 missing outputs: actual pending=%0d expected 0", sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule